// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines and decides which one the processor services next. It keeps three 8-bit registers: pending requests, levels in service, and a mask. It raises a single interrupt output when an unmasked request outranks everything in service. The processor answers with two acknowledge pulses. The first pulse picks the winning level and freezes it. The second pulse returns an 8-bit vector built from a programmed 5-bit base and the 3-bit level number.

Software drives the block through a small register port. This port has one address bit, write and read strobes, and 8-bit write and read buses. Through it, software can:
- clear in-service levels (non-specific, specific or automatic end-of-interrupt);
- rotate the priority ring or name its lowest level;
- switch to a special mask mode in which the mask also hides in-service levels;
- choose edge or level detection;
- read back the registers;
- poll, so that a read acts as the acknowledge.

Priority is a ring of eight levels. The only priority state is the level that currently ranks lowest. The level after it ranks highest.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, and after a configuration write (address 0, data bits 7:6 = 10; bit 0 selects edge detection, bit 1 automatic end-of-interrupt, bit 2 rotation on automatic end-of-interrupt), the in-service and mask registers are zero. Level 0 ranks highest and level 7 lowest, reads at address 0 return the request register, and the interrupt output is low.
- R2: The interrupt output is high only when some unmasked request ranks strictly above the highest in-service level. A request of equal or lower rank is held off until that level is cleared.
- R3: Control writes at address 0 with bits 7:6 = 01 carry a kind in bits 5:3 and a level in bits 2:0. Kind 001 clears the highest-ranked in-service bit. Kind 011 clears the in-service bit of the named level. An end-of-interrupt and a first acknowledge pulse in the same cycle both take effect.
- R4: Kind 101 clears the highest-ranked in-service bit and makes that level the lowest rank, so the next level in circular order ranks highest.
- R5: Kind 110 makes the named level the lowest rank and leaves the in-service register unchanged. Kind 111 clears the named in-service bit and also makes that level the lowest rank.
- R6: With automatic end-of-interrupt, the highest-ranked in-service bit clears on the second acknowledge pulse. With rotation also enabled, that level becomes the lowest rank.
- R7: A write at address 1 loads the mask. A masked request still shows in the request register and does not raise the interrupt. It raises the interrupt once unmasked if the input is still active.
- R8: A write at address 0 with bits 7:6 = 00 and bit 4 = 1 sets special mask mode from bit 3. In this mode every unmasked request that is not itself in service may interrupt, and the non-specific end-of-interrupt skips masked in-service levels.
- R9: In level mode, an input that stays active raises its request again after end-of-interrupt. In edge mode, a request needs a low-to-high transition; after its acknowledge it stays cleared until the input has gone low. After a configuration write, edge mode also needs the input to go low first.
- R10: A write at address 0 with bits 7:6 = 00 and bit 2 = 1 arms a poll. The next read returns bit 7 = request present, bits 6:3 = 0, and bits 2:0 = winning level, or 8'h07 when nothing is pending. That read also sets the winner's in-service bit.
- R11: A write at address 0 with bits 7:6 = 00 and bit 1 = 1 selects what address-0 reads return: the request register when bit 0 is 0, the in-service register when bit 0 is 1. Reads at address 1 return the mask. The read bus is zero while the read strobe is low.
- R12: A write at address 0 with bits 7:6 = 11 sets the vector base from bits 4:0. On the second acknowledge pulse the vector output carries {base, level} and the valid output is high.
- R13: The first acknowledge pulse freezes the winning level; requests arriving later do not change the vector. With no request at that pulse, the level is 7 and no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_i | input | 8 | Interrupt request lines, active high |
| a0_i | input | 1 | Register address bit |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| inta_i | input | 1 | Acknowledge pulse, one cycle each |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte on the second acknowledge pulse |
| vec_vld_o | output | 1 | High while vec_o carries a vector |

## Verification
An end-of-interrupt write and the first acknowledge pulse can land in the same cycle: one clears an in-service bit while the other sets a different one. The bench keeps level 3 in service and raises level 1. It then asserts the acknowledge pulse and a non-specific end-of-interrupt write on the same clock edge. The bench expects level 1 from the vector and an in-service readback of 8'h02, showing that the clear hit the old top level and the new bit survived.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    localparam int LVL_W  = 3;
    localparam int N_LVL  = 1 << LVL_W;
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - LVL_W;

    // decoded form of one register write
    typedef struct packed {
        logic             cfg;
        logic             set_base;
        logic             eoi_ns;
        logic             eoi_sp;
        logic             rot;
        logic             set_prio;
        logic             sel_upd;
        logic             sel_isr;
        logic             poll;
        logic             smm_upd;
        logic             smm_val;
        logic             mask_wr;
        logic [LVL_W-1:0] lvl;
    } cmd_t;

    // distance from the top of the ring: 0 is highest rank
    function automatic logic [LVL_W-1:0] prio_rank(input logic [LVL_W-1:0] lvl,
                                                   input logic [LVL_W-1:0] low);
        return lvl - low - LVL_W'(1);
    endfunction

    function automatic logic [N_LVL-1:0] lvl_bit(input logic [LVL_W-1:0] lvl);
        return N_LVL'(1) << lvl;
    endfunction

endpackage

// File: rtl/pic8_cmd_dec.sv
module pic8_cmd_dec
    import pic8_pkg::*;
(
    input  logic              wr_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] wdata_i,
    output cmd_t              cmd_o
);

    always_comb begin
        cmd_o     = '0;
        cmd_o.lvl = wdata_i[LVL_W-1:0];
        if (wr_i) begin
            if (a0_i) begin
                cmd_o.mask_wr = 1'b1;
            end else begin
                unique case (wdata_i[7:6])
                    2'b10: cmd_o.cfg      = 1'b1;
                    2'b11: cmd_o.set_base = 1'b1;
                    2'b01: begin
                        unique case (wdata_i[5:3])
                            3'b001: cmd_o.eoi_ns = 1'b1;
                            3'b101: begin cmd_o.eoi_ns = 1'b1; cmd_o.rot = 1'b1; end
                            3'b011: cmd_o.eoi_sp = 1'b1;
                            3'b111: begin cmd_o.eoi_sp = 1'b1; cmd_o.rot = 1'b1; end
                            3'b110: cmd_o.set_prio = 1'b1;
                            default: ;
                        endcase
                    end
                    default: begin
                        cmd_o.sel_upd = wdata_i[1];
                        cmd_o.sel_isr = wdata_i[0];
                        cmd_o.poll    = wdata_i[2];
                        cmd_o.smm_upd = wdata_i[4];
                        cmd_o.smm_val = wdata_i[3];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pic8_pick.sv
module pic8_pick #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [LW-1:0] low_i,
    output logic          found_o,
    output logic [LW-1:0] lvl_o
);

    logic [LW-1:0] idx;

    // walk the ring starting just after the lowest-ranked level
    always_comb begin
        found_o = 1'b0;
        lvl_o   = '1;
        idx     = '0;
        for (int k = 0; k < N; k++) begin
            idx = low_i + LW'(k + 1);
            if (!found_o && vec_i[idx]) begin
                found_o = 1'b1;
                lvl_o   = idx;
            end
        end
    end

endmodule

// File: rtl/pic8_reqlatch.sv
module pic8_reqlatch (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_i,
    input  logic edge_mode_i,
    input  logic init_i,
    input  logic clr_i,
    output logic req_d_o
);

    logic arm_d, arm_q;

    always_comb begin
        arm_d = arm_q;
        if (init_i)     arm_d = 1'b0;
        else if (!ir_i) arm_d = 1'b1;
        else if (clr_i) arm_d = 1'b0;
        req_d_o = ir_i & (!edge_mode_i | arm_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_d;
    end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  ir_i,
    input  logic              a0_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              inta_i,
    output logic              int_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_vld_o
);

    localparam int PAD_W = DATA_W - 1 - LVL_W;

    typedef struct packed {
        logic [N_LVL-1:0]  irr;
        logic [N_LVL-1:0]  isr;
        logic [N_LVL-1:0]  imr;
        logic [LVL_W-1:0]  low;
        logic [LVL_W-1:0]  lvl;
        logic              ack_ph;
        logic              poll;
        logic              sel_isr;
        logic              smm;
        logic              edge_m;
        logic              aeoi;
        logic              arot;
        logic [BASE_W-1:0] base;
    } st_t;

    st_t st_d, st_q;

    cmd_t             cmd;
    logic [N_LVL-1:0] cand, isr_eff, set_vec, req_vec;
    logic             req_found, top_found;
    logic [LVL_W-1:0] req_lvl, top_lvl, take_lvl;
    logic             ack1, ack2, poll_rd, take, edge_next;

    logic [N_LVL-1:0] irr_q, isr_q, imr_q;
    logic             poll_q;
    assign irr_q  = st_q.irr;
    assign isr_q  = st_q.isr;
    assign imr_q  = st_q.imr;
    assign poll_q = st_q.poll;

    pic8_cmd_dec u_dec (
        .wr_i    (wr_i),
        .a0_i    (a0_i),
        .wdata_i (wdata_i),
        .cmd_o   (cmd)
    );

    // candidates and effective in-service set depend on special mask mode
    assign cand    = st_q.smm ? (st_q.irr & ~st_q.imr & ~st_q.isr) : (st_q.irr & ~st_q.imr);
    assign isr_eff = st_q.smm ? (st_q.isr & ~st_q.imr) : st_q.isr;

    pic8_pick #(.N(N_LVL), .LW(LVL_W)) u_pick_req (
        .vec_i   (cand),
        .low_i   (st_q.low),
        .found_o (req_found),
        .lvl_o   (req_lvl)
    );

    pic8_pick #(.N(N_LVL), .LW(LVL_W)) u_pick_isr (
        .vec_i   (isr_eff),
        .low_i   (st_q.low),
        .found_o (top_found),
        .lvl_o   (top_lvl)
    );

    assign ack1      = inta_i & ~st_q.ack_ph;
    assign ack2      = inta_i &  st_q.ack_ph;
    assign poll_rd   = rd_i & st_q.poll;
    assign take      = ack1 | poll_rd;
    assign take_lvl  = req_found ? req_lvl : '1;
    assign set_vec   = (take && req_found) ? lvl_bit(req_lvl) : '0;
    assign edge_next = cmd.cfg ? wdata_i[0] : st_q.edge_m;

    for (genvar g = 0; g < N_LVL; g++) begin : g_req
        pic8_reqlatch u_lat (
            .clk         (clk),
            .rst_n       (rst_n),
            .ir_i        (ir_i[g]),
            .edge_mode_i (edge_next),
            .init_i      (cmd.cfg),
            .clr_i       (set_vec[g]),
            .req_d_o     (req_vec[g])
        );
    end

    assign int_o = req_found &&
                   (st_q.smm || !top_found ||
                    (prio_rank(req_lvl, st_q.low) < prio_rank(top_lvl, st_q.low)));

    always_comb begin
        logic [N_LVL-1:0] clr;
        st_d     = st_q;
        st_d.irr = req_vec;
        clr      = '0;

        if (ack2 && st_q.aeoi && top_found) begin
            clr |= lvl_bit(top_lvl);
            if (st_q.arot) st_d.low = top_lvl;
        end
        if (cmd.eoi_ns && top_found) begin
            clr |= lvl_bit(top_lvl);
            if (cmd.rot) st_d.low = top_lvl;
        end
        if (cmd.eoi_sp) begin
            clr |= lvl_bit(cmd.lvl);
            if (cmd.rot) st_d.low = cmd.lvl;
        end
        if (cmd.set_prio) st_d.low = cmd.lvl;

        st_d.isr = (st_q.isr | set_vec) & ~clr;

        if (ack1) begin
            st_d.ack_ph = 1'b1;
            st_d.lvl    = take_lvl;
        end
        if (ack2)         st_d.ack_ph  = 1'b0;
        if (poll_rd)      st_d.poll    = 1'b0;
        if (cmd.poll)     st_d.poll    = 1'b1;
        if (cmd.mask_wr)  st_d.imr     = wdata_i;
        if (cmd.set_base) st_d.base    = wdata_i[BASE_W-1:0];
        if (cmd.sel_upd)  st_d.sel_isr = cmd.sel_isr;
        if (cmd.smm_upd)  st_d.smm     = cmd.smm_val;

        if (cmd.cfg) begin
            st_d.isr     = '0;
            st_d.imr     = '0;
            st_d.low     = '1;
            st_d.smm     = 1'b0;
            st_d.sel_isr = 1'b0;
            st_d.poll    = 1'b0;
            st_d.ack_ph  = 1'b0;
            st_d.edge_m  = wdata_i[0];
            st_d.aeoi    = wdata_i[1];
            st_d.arot    = wdata_i[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.low  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (st_q.poll)        rdata_o = {req_found, {PAD_W{1'b0}}, take_lvl};
            else if (a0_i)        rdata_o = st_q.imr;
            else if (st_q.sel_isr) rdata_o = st_q.isr;
            else                  rdata_o = st_q.irr;
        end
    end

    assign vec_vld_o = ack2;
    assign vec_o     = {st_q.base, st_q.lvl};

endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
    import pic8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_i,
    input logic              a0_i,
    input logic              rd_i,
    input logic              int_o,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [N_LVL-1:0]  ir_i,
    input logic [N_LVL-1:0]  irr_q,
    input logic [N_LVL-1:0]  isr_q,
    input logic [N_LVL-1:0]  imr_q,
    input logic              poll_q
);

    assert_cfg_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !a0_i && wdata_i[7:6] == 2'b10) |=> (isr_q == '0 && imr_q == '0));

    assert_int_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((irr_q & ~imr_q) != '0));

    assert_isr_from_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr_q & ~$past(isr_q) & ~$past(irr_q & ~imr_q)) == '0));

    assert_irr_follows_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr_q & ~$past(ir_i)) == '0));

    assert_empty_poll_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && poll_q && ((irr_q & ~imr_q) == '0)) |-> (rdata_o == DATA_W'(N_LVL - 1)));

endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_i),
    .a0_i    (a0_i),
    .rd_i    (rd_i),
    .int_o   (int_o),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ir_i    (ir_i),
    .irr_q   (irr_q),
    .isr_q   (isr_q),
    .imr_q   (imr_q),
    .poll_q  (poll_q)
);

// File: tb/pic8_ctrl_test.sv
module pic8_ctrl_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] ir = '0, wdata = '0;
    logic       a0 = 1'b0, wr = 1'b0, rd = 1'b0, inta = 1'b0;
    logic [7:0] rdata, vec;
    logic       intr, vld;

    int vectors = 0, miscmp = 0;

    always #(CLK_P/2) clk = ~clk;

    pic8_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ir_i(ir), .a0_i(a0), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .inta_i(inta), .int_o(intr),
        .vec_o(vec), .vec_vld_o(vld)
    );

    localparam logic [7:0] NSEOI = 8'h48, NSROT = 8'h68, POLL = 8'h04;
    localparam logic [7:0] SEL_IRR = 8'h02, SEL_ISR = 8'h03, SMM_ON = 8'h18, SMM_OFF = 8'h10;

    function automatic logic [7:0] spe(input logic [2:0] l);  return 8'h58 | l; endfunction
    function automatic logic [7:0] spr(input logic [2:0] l);  return 8'h78 | l; endfunction
    function automatic logic [7:0] setp(input logic [2:0] l); return 8'h70 | l; endfunction
    function automatic logic [7:0] vbyte(input logic [4:0] b, input logic [2:0] l); return {b, l}; endfunction

    // first set bit walking the ring after the lowest level
    function automatic logic [2:0] ring_pick(input logic [7:0] v, input logic [2:0] low);
        for (int k = 1; k <= 8; k++) begin
            logic [2:0] idx = low + 3'(k);
            if (v[idx]) return idx;
        end
        return 3'd7;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscmp++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wrb(input logic a, input logic [7:0] d);
        @(negedge clk); a0 = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rdb(input logic a, output logic [7:0] d);
        @(negedge clk); a0 = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic set_ir(input logic [7:0] v);
        @(negedge clk); ir = v;
        @(negedge clk);
    endtask

    task automatic ack1();
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic ack2(input string tag, input logic [7:0] exp);
        logic [7:0] v; logic ok;
        @(negedge clk); inta = 1'b1; #1 v = vec; ok = vld;
        @(negedge clk); inta = 1'b0;
        chk({tag, " vector"}, v, exp);
        chk({tag, " valid"}, {7'd0, ok}, 8'h01);
    endtask

    task automatic ack(input string tag, input logic [7:0] exp);
        ack1(); ack2(tag, exp);
    endtask

    task automatic chk_int(input string tag, input logic exp);
        chk(tag, {7'd0, intr}, {7'd0, exp});
    endtask

    initial begin
        #(CLK_P * 150000);
        miscmp++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [2:0] low;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk_int("R1 int after reset", 1'b0);
        rdb(0, d); chk("R1 irr after reset", d, 8'h00);
        rdb(1, d); chk("R1 mask after reset", d, 8'h00);

        // R2 R11 R12 nesting and vector
        wrb(0, 8'hC0 | 8'h15);
        set_ir(8'h08); chk_int("R2 single request", 1'b1);
        ack("R12 level3", vbyte(5'h15, 3));
        wrb(0, SEL_ISR);
        rdb(0, d); chk("R11 isr readback", d, 8'h08);
        chk_int("R2 equal level held", 1'b0);
        set_ir(8'h28); chk_int("R2 lower level held", 1'b0);
        set_ir(8'h2A); chk_int("R2 higher level interrupts", 1'b1);
        ack("R2 nested level1", vbyte(5'h15, 1));
        rdb(0, d); chk("R2 two in service", d, 8'h0A);
        wrb(0, NSEOI); rdb(0, d); chk("R3 non-specific clears top", d, 8'h08);
        wrb(0, spe(3)); rdb(0, d); chk("R3 specific clears named", d, 8'h00);
        set_ir(8'h00);

        // R3 acknowledge and end-of-interrupt in the same cycle
        set_ir(8'h08); ack("R3 setup", vbyte(5'h15, 3));
        set_ir(8'h0A);
        @(negedge clk); inta = 1'b1; a0 = 1'b0; wdata = NSEOI; wr = 1'b1;
        @(negedge clk); inta = 1'b0; wr = 1'b0;
        ack2("R3 concurrent", vbyte(5'h15, 1));
        rdb(0, d); chk("R3 concurrent isr", d, 8'h02);
        wrb(0, NSEOI); set_ir(8'h00);

        // R4 rotation on end-of-interrupt
        set_ir(8'h10); ack("R4 level4", vbyte(5'h15, 4));
        wrb(0, NSROT); rdb(0, d); chk("R4 isr cleared", d, 8'h00);
        set_ir(8'h28); ack("R4 rotated winner", vbyte(5'h15, 5));
        wrb(0, NSEOI);

        // R5 set priority and specific rotate
        ack("R5 setup", vbyte(5'h15, 5));
        wrb(0, setp(2)); rdb(0, d); chk("R5 set-priority keeps isr", d, 8'h20);
        set_ir(8'h0A); chk_int("R5 level3 outranks", 1'b1);
        ack("R5 level3", vbyte(5'h15, 3));
        wrb(0, spr(3)); rdb(0, d); chk("R5 specific rotate clears", d, 8'h20);
        set_ir(8'h14); ack("R5 level4 now top", vbyte(5'h15, 4));
        wrb(0, NSEOI); rdb(0, d); chk("R5 top after rotate", d, 8'h20);
        wrb(0, NSEOI); set_ir(8'h00);

        // R6 automatic end-of-interrupt
        wrb(0, 8'h82); wrb(0, SEL_ISR);
        set_ir(8'h04); ack("R6 level2", vbyte(5'h15, 2));
        rdb(0, d); chk("R6 auto clear", d, 8'h00);
        set_ir(8'h00);
        wrb(0, 8'h86); wrb(0, SEL_ISR);
        set_ir(8'h04); ack("R6 rotate setup", vbyte(5'h15, 2));
        set_ir(8'h0A); ack("R6 auto rotate", vbyte(5'h15, 3));
        set_ir(8'h00);

        // R7 mask
        wrb(0, 8'h80);
        wrb(1, 8'h04);
        set_ir(8'h04); chk_int("R7 masked no int", 1'b0);
        rdb(0, d); chk("R7 masked still pending", d, 8'h04);
        rdb(1, d); chk("R11 mask readback", d, 8'h04);
        wrb(1, 8'h00); chk_int("R7 fires when unmasked", 1'b1);
        ack("R7 level2", vbyte(5'h15, 2));
        wrb(0, NSEOI); set_ir(8'h00);

        // R8 special mask mode
        set_ir(8'h02); ack("R8 setup", vbyte(5'h15, 1));
        wrb(1, 8'h02);
        set_ir(8'h22); chk_int("R8 nested blocks level5", 1'b0);
        wrb(0, SMM_ON); chk_int("R8 special mask lets level5", 1'b1);
        ack("R8 level5", vbyte(5'h15, 5));
        wrb(0, SEL_ISR); rdb(0, d); chk("R8 both in service", d, 8'h22);
        wrb(0, NSEOI); rdb(0, d); chk("R8 eoi skips masked", d, 8'h02);
        wrb(0, SMM_OFF); wrb(0, spe(1)); wrb(1, 8'h00); set_ir(8'h00);

        // R9 edge versus level
        set_ir(8'h40);
        wrb(0, 8'h81); chk_int("R9 edge needs transition", 1'b0);
        set_ir(8'h00); set_ir(8'h40); chk_int("R9 edge rising", 1'b1);
        ack("R9 edge level6", vbyte(5'h15, 6));
        wrb(0, NSEOI); chk_int("R9 edge locked out", 1'b0);
        rdb(0, d); chk("R9 edge irr cleared", d, 8'h00);
        wrb(0, 8'h80); chk_int("R9 level pending", 1'b1);
        ack("R9 level6", vbyte(5'h15, 6));
        wrb(0, NSEOI); chk_int("R9 level re-raises", 1'b1);
        set_ir(8'h00);

        // R10 poll
        set_ir(8'h30); wrb(0, POLL);
        rdb(0, d); chk("R10 poll word", d, 8'h84);
        wrb(0, SEL_ISR); rdb(0, d); chk("R10 poll sets isr", d, 8'h10);
        wrb(0, NSEOI); set_ir(8'h00);
        wrb(0, POLL); rdb(0, d); chk("R10 empty poll", d, 8'h07);
        rdb(1, d); chk("R11 mask after poll", d, 8'h00);

        // R13 frozen level and empty acknowledge
        ack("R13 empty ack", vbyte(5'h15, 7));
        rdb(0, d); chk("R13 no isr set", d, 8'h00);
        set_ir(8'h08); ack1();
        set_ir(8'h0A); ack2("R13 frozen", vbyte(5'h15, 3));
        wrb(0, NSEOI); set_ir(8'h00);

        // R2 R4 R12 random patterns
        wrb(0, 8'h80); low = 3'd7;
        for (int i = 0; i < 60; i++) begin
            logic [4:0] b = 5'($urandom);
            logic [7:0] m = 8'($urandom);
            logic [7:0] v = 8'($urandom);
            logic [2:0] w;
            wrb(0, 8'hC0 | {3'd0, b});
            wrb(1, m);
            set_ir(v);
            chk_int("R2 random int", |(v & ~m));
            if (|(v & ~m)) begin
                w = ring_pick(v & ~m, low);
                ack("R12 random vector", vbyte(b, w));
                if ($urandom % 2 == 1) begin wrb(0, NSROT); low = w; end
                else wrb(0, NSEOI);
            end
            set_ir(8'h00);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule